// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block keeps the fault-reporting registers of a translation unit. Each cycle a lookup request may arrive. It carries a virtual address, an access-class index, a store flag, the processor privilege state, an address-space identifier and a trap-level flag. In the same cycle the translation buffer returns a one-hot hit vector and a per-entry privileged flag vector. The block works out the active context and a two-bit context kind. A privileged entry hit by a user-class access is a protection fault. On a protection fault the block writes a new 64-bit status word and loads the fault-address register. When no entry hits, only the tag-access register is loaded. A hit that is allowed leaves all three registers as they are.

The request side is a valid/ready stream that never applies back-pressure. `req_ready` is held high, so every cycle with `req_valid` high is one accepted lookup. The hit and privileged vectors are sampled only in that cycle. Software sees the registers directly on the outputs. A one-cycle `sw_clr` pulse empties the status register. Parameter `INSTR_SIDE` selects the fetch-side variant, in which a fault taken above trap level zero reports the nucleus context kind.

Top module: `mmu_fault_capture`

## Requirements
- R1: After a synchronous active-high reset, the status, fault-address and tag-access outputs are all zero.
- R2: `req_ready` is always 1. A cycle with `req_valid` low and `sw_clr` low leaves all three registers unchanged, whatever the other inputs are.
- R3: The active context is `pctx` for index 0 (user primary) and 1 (kernel primary). It is `sctx` for index 2 (user secondary) and 3 (kernel secondary). It is 0 for index 4 (nucleus) and for indices 5 to 7.
- R4: Status bits 5:4 hold the context kind: 0 for primary indices, 1 for secondary indices, 2 for nucleus. Code 3 is no-translation.
- R5: A fault occurs when `req_valid` is high, the index is 0 or 2, and some entry has both its hit and privileged bits set. The register update is seen on the outputs one cycle later: status bit 0 (valid) and bit 7 (privilege violation) are set, and the fault-address output equals the request address.
- R6: A hit with no fault leaves status, fault-address and tag-access unchanged. This covers a privileged entry hit from a kernel index and a non-privileged entry hit from any index.
- R7: In a fault status word, bit 2 equals the store flag, bit 3 equals the processor privilege input, and bits 23:16 equal the request ASI. Every bit not named in R4, R5, R7 or R8 is zero.
- R8: A fault replaces the whole status word. Bit 1 (overwritten) is set exactly when the previous status had bit 0 set.
- R9: A miss (`req_valid` high, no hit bit set) leaves status and fault-address unchanged. It loads tag-access with the request address, its low 13 bits replaced by the active context.
- R10: `sw_clr` sets the status to zero. When a fault arrives in the same cycle, the clear takes effect first: the new word has bit 1 clear.
- R11: With `INSTR_SIDE`=1, a fault with `req_tl_nz` high reports context kind 2. With `INSTR_SIDE`=0, `req_tl_nz` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Always high; no back-pressure |
| req_va | input | VA_W | Virtual address of the request |
| req_idx | input | 3 | Access-class index |
| req_write | input | 1 | Request is a store |
| req_priv | input | 1 | Processor privilege state |
| req_asi | input | 8 | Address-space identifier |
| req_tl_nz | input | 1 | Trap level above zero |
| tlb_hit | input | N_ENT | Per-entry match vector |
| tlb_priv | input | N_ENT | Per-entry privileged flag |
| pctx | input | CTX_W | Primary context |
| sctx | input | CTX_W | Secondary context |
| sw_clr | input | 1 | Software clear of the status register |
| status_o | output | 64 | Fault status register |
| fault_addr_o | output | VA_W | Fault address register |
| tag_access_o | output | VA_W | Tag-access register |

## Verification
Two collisions are checked. The first is a software clear in the same cycle as a fault. The bench stages a fault, then applies the next fault together with `sw_clr`. It judges the collision by bit 1 of the new word, which must be clear, and by bit 0, which must be set. The second is a clear in the same cycle as a miss. Here the status must go to zero while tag-access still loads. Random traffic with sparse clears repeats both collisions. Every output of both variants is compared against the bench model each cycle.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int ST_W       = 64;
  localparam int B_VALID    = 0;
  localparam int B_OVWR     = 1;
  localparam int B_STORE    = 2;
  localparam int B_PRIVMODE = 3;
  localparam int B_KIND     = 4;
  localparam int B_PRIVFLT  = 7;
  localparam int B_ASI      = 16;
  localparam int ASI_W      = 8;

  typedef enum logic [1:0] {
    KIND_PRI  = 2'd0,
    KIND_SEC  = 2'd1,
    KIND_NUC  = 2'd2,
    KIND_NONE = 2'd3
  } ctx_kind_e;

  typedef enum logic [2:0] {
    IX_USR_PRI = 3'd0,
    IX_KRN_PRI = 3'd1,
    IX_USR_SEC = 3'd2,
    IX_KRN_SEC = 3'd3,
    IX_NUC     = 3'd4
  } acc_idx_e;
endpackage

// File: rtl/fsc_ctx_sel.sv
module fsc_ctx_sel
  import fsc_pkg::*;
#(
  parameter int CTX_W = 13
) (
  input  logic [2:0]       idx,
  input  logic [CTX_W-1:0] pctx,
  input  logic [CTX_W-1:0] sctx,
  output logic [CTX_W-1:0] ctx_o,
  output ctx_kind_e        kind_o,
  output logic             user_o
);
  always_comb begin
    ctx_o  = '0;
    kind_o = KIND_NONE;
    user_o = 1'b0;
    case (idx)
      IX_USR_PRI: begin ctx_o = pctx; kind_o = KIND_PRI; user_o = 1'b1; end
      IX_KRN_PRI: begin ctx_o = pctx; kind_o = KIND_PRI; end
      IX_USR_SEC: begin ctx_o = sctx; kind_o = KIND_SEC; user_o = 1'b1; end
      IX_KRN_SEC: begin ctx_o = sctx; kind_o = KIND_SEC; end
      IX_NUC:     kind_o = KIND_NUC;
      default:    kind_o = KIND_NONE;
    endcase
  end
endmodule

// File: rtl/fsc_tlb_reduce.sv
module fsc_tlb_reduce #(
  parameter int N_ENT = 64
) (
  input  logic [N_ENT-1:0] hit_vec,
  input  logic [N_ENT-1:0] priv_vec,
  output logic             any_hit_o,
  output logic             priv_hit_o
);
  logic [N_ENT-1:0] priv_match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign priv_match[g] = hit_vec[g] & priv_vec[g];
  end

  assign any_hit_o  = |hit_vec;
  assign priv_hit_o = |priv_match;
endmodule

// File: rtl/fsc_word_build.sv
module fsc_word_build
  import fsc_pkg::*;
#(
  parameter bit INSTR_SIDE = 1'b0
) (
  input  ctx_kind_e        kind,
  input  logic             tl_nz,
  input  logic             store,
  input  logic             priv_mode,
  input  logic [ASI_W-1:0] asi,
  input  logic             prev_valid,
  output logic [ST_W-1:0]  word_o
);
  ctx_kind_e kind_eff;

  assign kind_eff = (INSTR_SIDE && tl_nz) ? KIND_NUC : kind;

  always_comb begin
    word_o                     = '0;
    word_o[B_VALID]            = 1'b1;
    word_o[B_OVWR]             = prev_valid;
    word_o[B_STORE]            = store;
    word_o[B_PRIVMODE]         = priv_mode;
    word_o[B_KIND +: 2]        = kind_eff;
    word_o[B_PRIVFLT]          = 1'b1;
    word_o[B_ASI +: ASI_W]     = asi;
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import fsc_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int N_ENT      = 64,
  parameter int CTX_W      = 13,
  parameter bit INSTR_SIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [2:0]       req_idx,
  input  logic             req_write,
  input  logic             req_priv,
  input  logic [ASI_W-1:0] req_asi,
  input  logic             req_tl_nz,
  input  logic [N_ENT-1:0] tlb_hit,
  input  logic [N_ENT-1:0] tlb_priv,
  input  logic [CTX_W-1:0] pctx,
  input  logic [CTX_W-1:0] sctx,
  input  logic             sw_clr,
  output logic [ST_W-1:0]  status_o,
  output logic [VA_W-1:0]  fault_addr_o,
  output logic [VA_W-1:0]  tag_access_o
);
  logic [CTX_W-1:0] ctx;
  ctx_kind_e        kind;
  logic             user_acc, any_hit, priv_hit;
  logic             do_fault, do_miss, prev_valid;
  logic [ST_W-1:0]  new_word;
  logic [ST_W-1:0]  status_q;
  logic [VA_W-1:0]  fault_addr_q, tag_access_q;

  assign req_ready = 1'b1;

  fsc_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
    .idx(req_idx), .pctx(pctx), .sctx(sctx),
    .ctx_o(ctx), .kind_o(kind), .user_o(user_acc)
  );

  fsc_tlb_reduce #(.N_ENT(N_ENT)) u_red (
    .hit_vec(tlb_hit), .priv_vec(tlb_priv),
    .any_hit_o(any_hit), .priv_hit_o(priv_hit)
  );

  assign do_fault   = req_valid & user_acc & priv_hit;
  assign do_miss    = req_valid & ~any_hit;
  assign prev_valid = status_q[B_VALID] & ~sw_clr;

  fsc_word_build #(.INSTR_SIDE(INSTR_SIDE)) u_word (
    .kind(kind), .tl_nz(req_tl_nz), .store(req_write),
    .priv_mode(req_priv), .asi(req_asi), .prev_valid(prev_valid),
    .word_o(new_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q     <= '0;
      fault_addr_q <= '0;
      tag_access_q <= '0;
    end else begin
      if (do_fault) begin
        status_q     <= new_word;
        fault_addr_q <= req_va;
      end else if (sw_clr) begin
        status_q <= '0;
      end
      if (do_miss) begin
        tag_access_q <= {req_va[VA_W-1:CTX_W], ctx};
      end
    end
  end

  assign status_o     = status_q;
  assign fault_addr_o = fault_addr_q;
  assign tag_access_o = tag_access_q;

  AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(|tlb_hit) && !sw_clr) |=> ($stable(status_o) && $stable(fault_addr_o))); // R9
  AST_FAULT_MARKS: assert property (@(posedge clk) disable iff (rst)
    do_fault |=> (status_o[B_VALID] && status_o[B_PRIVFLT] && fault_addr_o == $past(req_va))); // R5
  AST_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (do_fault && status_o[B_VALID] && !sw_clr) |=> status_o[B_OVWR]); // R8
  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (do_fault && sw_clr) |=> !status_o[B_OVWR]); // R10
  AST_NUC_TAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(|tlb_hit) && req_idx == 3'd4) |=> (tag_access_o[CTX_W-1:0] == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !sw_clr) |=> ($stable(status_o) && $stable(tag_access_o))); // R2
endmodule

// File: tb/tb_mmu_fault_capture.sv
module tb_mmu_fault_capture;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W  = 64;
  localparam int N_ENT = 64;
  localparam int CTX_W = 13;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             rst, req_valid, req_write, req_priv, req_tl_nz, sw_clr;
  logic [VA_W-1:0]  req_va;
  logic [2:0]       req_idx;
  logic [7:0]       req_asi;
  logic [N_ENT-1:0] tlb_hit, tlb_priv;
  logic [CTX_W-1:0] pctx, sctx;
  logic             rdy_d, rdy_i;
  logic [63:0]      st_d, st_i;
  logic [VA_W-1:0]  fa_d, fa_i, ta_d, ta_i;

  mmu_fault_capture #(.INSTR_SIDE(1'b0)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_d),
    .req_va(req_va), .req_idx(req_idx), .req_write(req_write),
    .req_priv(req_priv), .req_asi(req_asi), .req_tl_nz(req_tl_nz),
    .tlb_hit(tlb_hit), .tlb_priv(tlb_priv), .pctx(pctx), .sctx(sctx),
    .sw_clr(sw_clr), .status_o(st_d), .fault_addr_o(fa_d), .tag_access_o(ta_d));

  mmu_fault_capture #(.INSTR_SIDE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_i),
    .req_va(req_va), .req_idx(req_idx), .req_write(req_write),
    .req_priv(req_priv), .req_asi(req_asi), .req_tl_nz(req_tl_nz),
    .tlb_hit(tlb_hit), .tlb_priv(tlb_priv), .pctx(pctx), .sctx(sctx),
    .sw_clr(sw_clr), .status_o(st_i), .fault_addr_o(fa_i), .tag_access_o(ta_i));

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [63:0] m_st [2];
  logic [63:0] m_fa [2];
  logic [63:0] m_ta [2];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [63:0] ns [2];
    logic [63:0] nf [2];
    logic [63:0] nt [2];
    logic [12:0] cx;
    int kd;
    bit usr, flt, mis;
    for (int s = 0; s < 2; s++) begin
      ns[s] = m_st[s]; nf[s] = m_fa[s]; nt[s] = m_ta[s];
      if (rst) begin
        ns[s] = 0; nf[s] = 0; nt[s] = 0;
      end else begin
        cx = (req_idx < 2) ? pctx : (req_idx < 4) ? sctx : 13'd0;
        kd = (req_idx < 2) ? 0 : (req_idx < 4) ? 1 : (req_idx == 4) ? 2 : 3;
        if (s == 1 && req_tl_nz) kd = 2;
        usr = (req_idx == 0) || (req_idx == 2);
        flt = req_valid && usr && ((tlb_hit & tlb_priv) != 0);
        mis = req_valid && (tlb_hit == 0);
        if (flt) begin
          ns[s] = 64'd1 | (64'(req_write) << 2) | (64'(req_priv) << 3) |
                  (64'(kd) << 4) | (64'd1 << 7) | (64'(req_asi) << 16);
          if (m_st[s][0] && !sw_clr) ns[s] = ns[s] | 64'd2;
          nf[s] = req_va;
        end else if (sw_clr) begin
          ns[s] = 0;
        end
        if (mis) nt[s] = (req_va & ~64'h1fff) | 64'(cx);
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      m_st[s] = ns[s]; m_fa[s] = nf[s]; m_ta[s] = nt[s];
    end
    chk(tag, "ready", {63'd0, rdy_d & rdy_i}, 64'd1);
    chk(tag, "status_d", st_d, m_st[0]);
    chk(tag, "faddr_d", fa_d, m_fa[0]);
    chk(tag, "tag_d", ta_d, m_ta[0]);
    chk(tag, "status_i", st_i, m_st[1]);
    chk(tag, "faddr_i", fa_i, m_fa[1]);
    chk(tag, "tag_i", ta_i, m_ta[1]);
  endtask

  task automatic req(bit v, int ix, bit wr, bit pv, int asi, bit tl,
                     logic [63:0] va, int ent, bit ent_priv, bit clr);
    req_valid = v; req_idx = 3'(ix); req_write = wr; req_priv = pv;
    req_asi = 8'(asi); req_tl_nz = tl; req_va = va; sw_clr = clr;
    tlb_hit  = (ent < 0) ? '0 : (64'd1 << ent);
    tlb_priv = (ent < 0) ? '0 : (ent_priv ? (64'd1 << ent) : ~(64'd1 << ent));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int s = 0; s < 2; s++) begin m_st[s] = 0; m_fa[s] = 0; m_ta[s] = 0; end
    rst = 1'b1; pctx = 13'h1abc; sctx = 13'h0123;
    req(1, 0, 1, 1, 8'h77, 1, 64'hdead_beef_0000_1234, 5, 1, 0);
    @(negedge clk);
    step("R1"); step("R1");
    rst = 1'b0;
    req(0, 0, 1, 1, 8'h77, 1, 64'hdead_beef_0000_1234, 5, 1, 0);
    step("R2");
    req(0, 3, 0, 0, 8'h11, 0, 64'h0, -1, 0, 0);
    step("R2");
    // misses: context selection and tag-access
    req(1, 0, 0, 0, 0, 0, 64'hffff_ffff_ffff_ffff, -1, 0, 0); step("R9");
    req(1, 1, 0, 0, 0, 0, 64'h1234_5678_9abc_def0, -1, 0, 0); step("R3");
    req(1, 3, 0, 0, 0, 0, 64'h0000_0000_0000_3fff, -1, 0, 0); step("R3");
    req(1, 4, 0, 0, 0, 0, 64'hffff_0000_ffff_ffff, -1, 0, 0); step("R3");
    req(1, 6, 0, 0, 0, 0, 64'h0f0f_0f0f_0f0f_0f0f, -1, 0, 0); step("R3");
    // allowed hits
    req(1, 1, 1, 1, 8'h22, 0, 64'h1111, 9, 1, 0); step("R6");
    req(1, 0, 1, 0, 8'h22, 0, 64'h2222, 63, 0, 0); step("R6");
    req(1, 4, 0, 1, 8'h22, 0, 64'h3333, 0, 1, 0); step("R6");
    // faults
    req(1, 0, 1, 1, 8'h5a, 0, 64'hcafe_0000_0000_8000, 12, 1, 0); step("R5");
    req(1, 2, 0, 0, 8'ha5, 0, 64'h0000_4444_0000_0001, 40, 1, 0); step("R8");
    req(1, 2, 1, 0, 8'hff, 1, 64'h7777, 63, 1, 0); step("R11");
    req(0, 0, 0, 0, 0, 0, 64'h0, -1, 0, 1); step("R10");
    req(1, 0, 0, 1, 8'h01, 0, 64'h9999, 0, 1, 0); step("R7");
    req(1, 0, 1, 1, 8'h80, 1, 64'haaaa, 3, 1, 1); step("R10");
    req(1, 5, 0, 0, 0, 0, 64'hbbbb_0000_0000_0000, -1, 0, 1); step("R10");
    req(1, 2, 1, 1, 8'h3c, 1, 64'h5555_5555, 7, 1, 0); step("R4");
    req(0, 0, 0, 0, 0, 0, 64'h0, -1, 0, 0); step("R2");
    // random traffic
    for (int k = 0; k < 800; k++) begin
      req(($urandom % 8) != 0, int'($urandom % 8), 1'($urandom), 1'($urandom),
          int'($urandom % 256), 1'($urandom), {$urandom, $urandom},
          (($urandom % 4) == 0) ? -1 : int'($urandom % 64), 1'($urandom),
          ($urandom % 8) == 0);
      pctx = 13'($urandom); sctx = 13'($urandom);
      step("R8");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule